// File: doc/BRIEF.md
# Opcode-Steered 16-bit Arithmetic/Logic Unit

This block is the arithmetic and logic core of a small 16-bit processor. It takes an 8-bit opcode, a destination operand and a source operand, and it produces a result in the same cycle. It keeps seven condition flags in a register, which updates on the clock edge. The carry held in that register is the carry input to shifts, so a chain of shift instructions moves bits through the carry.

Some opcode bits steer the datapath directly, with no separate operation code behind them:

- Bit 5 turns the shared adder into a subtractor.
- Bit 4 replaces the source operand with the constant one, for increment and decrement.
- Bit 4 also decides whether a shift feeds the carry back in or closes the loop as a rotate.
- The adder is built from four quarter-width segments. The carries between those segments are exported as flags next to the final carry.

The surrounding core presents an opcode and its operands with `en` high for one cycle per instruction. It reads `result_o` combinationally in that cycle. It sees the new flags on `flags_o` after the clock edge.

Top module: `opalu`

## Requirements
- R1: The legal opcodes are exactly 0x40, 0x41, 0x42, 0x43, 0x45, 0x46, 0x47, 0x48, 0x55, 0x56, 0x57, 0x65 and 0x75. For any other opcode, `illegal_o` is 1, `result_o` is 0 and the flags do not change.
- R2: Opcode 0x45 gives dst+src and opcode 0x55 gives dst+1, both modulo 2^16.
- R3: Opcode 0x65 gives dst-src and opcode 0x75 gives dst-1, computed as dst + ~operand + 1, modulo 2^16.
- R4: On the four adder opcodes, the carry flags are set as follows: `flags_o[0]` (C) is the carry out of bit 15, `flags_o[1]` (QC) the carry out of bit 3, `flags_o[2]` (HC) the carry out of bit 7, and `flags_o[3]` (TC) the carry out of bit 11. All four carries come from the same addition, including the inverted operand and the carry-in of one on subtraction.
- R5: On the four adder opcodes, `flags_o[4]` (Z) is set when the result is zero and `flags_o[5]` (N) equals result bit 15. `flags_o[6]` (V) is set when both adder inputs share a sign and the result sign differs from it.
- R6: Opcodes 0x40 (NOT of dst), 0x41 (XOR), 0x42 (AND) and 0x43 (OR) update only Z. The other six flags keep their values.
- R7: Opcode 0x46 shifts dst left: the old carry enters bit 0 and the old bit 15 becomes the carry. Opcode 0x47 shifts dst right: the old carry enters bit 15 and the old bit 0 becomes the carry. Both update C and Z only.
- R8: Opcode 0x56 rotates dst left by one bit and opcode 0x57 rotates it right by one bit, with no carry in the loop. Neither opcode changes any flag.
- R9: Opcode 0x48 exchanges the high and low bytes of dst and changes no flag.
- R10: The flags change only on a clock edge where `en` is 1 and the opcode is legal. With `en` at 0 the flags hold, and the result output still shows the operation.
- R11: While reset is active, and after it is released, all seven flags are 0 until the first enabled legal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Commit the operation's flags on this edge |
| opcode | input | 8 | Arithmetic/logic opcode |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| result_o | output | 16 | Combinational result |
| illegal_o | output | 1 | Opcode is not a legal arithmetic/logic code |
| flags_o | output | 7 | Registered flags {V,N,Z,TC,HC,QC,C} |

## Verification
The adder is driven with operand pairs chosen to separate its flags:

- 0xFFFF+1 makes every carry ripple at once.
- 0x0F0F+1 carries out of bit 3 only.
- 0x7FFF+1 gives a signed overflow with no final carry.
- Equal-operand subtraction shows the no-borrow carry with a zero result.
- A decrement of zero shows a borrow.
- A decrement of 0x8000 shows a negative-to-positive overflow.

Shifts are run back to back with the carry first set and then cleared. This shows whether the carry is really in the loop, and that the rotates leave it out. Logic operations and byte swaps follow flag-setting additions, which shows whether the untouched flags survive. Illegal codes, both inside and outside the class, and disabled cycles are interleaved with a long random stream so that held flags can be told apart from updated ones.

// File: rtl/opalu_pkg.sv
package opalu_pkg;

   localparam int FLAG_W = 7;
   localparam int F_C  = 0;
   localparam int F_QC = 1;
   localparam int F_HC = 2;
   localparam int F_TC = 3;
   localparam int F_Z  = 4;
   localparam int F_N  = 5;
   localparam int F_V  = 6;

   localparam logic [7:0] OP_NOT = 8'h40;
   localparam logic [7:0] OP_XOR = 8'h41;
   localparam logic [7:0] OP_AND = 8'h42;
   localparam logic [7:0] OP_OR  = 8'h43;
   localparam logic [7:0] OP_ADD = 8'h45;
   localparam logic [7:0] OP_SHL = 8'h46;
   localparam logic [7:0] OP_SHR = 8'h47;
   localparam logic [7:0] OP_SWP = 8'h48;
   localparam logic [7:0] OP_INC = 8'h55;
   localparam logic [7:0] OP_ROL = 8'h56;
   localparam logic [7:0] OP_ROR = 8'h57;
   localparam logic [7:0] OP_SUB = 8'h65;
   localparam logic [7:0] OP_DEC = 8'h75;

   typedef enum logic [2:0] {
      U_NONE,
      U_ADD,
      U_LOGIC,
      U_SHIFT,
      U_SWAP
   } unit_e;

   typedef struct packed {
      logic  legal;
      unit_e unit;
      logic  upd_arith;
      logic  upd_cz;
      logic  upd_z;
   } dec_t;

endpackage

// File: rtl/opalu_decode.sv
module opalu_decode
   import opalu_pkg::*;
(
   input  logic [7:0] opcode,
   output dec_t       dec
);

   always_comb begin
      dec = '{legal: 1'b0, unit: U_NONE, upd_arith: 1'b0, upd_cz: 1'b0, upd_z: 1'b0};
      unique case (opcode)
         OP_ADD, OP_INC, OP_SUB, OP_DEC: begin
            dec.legal     = 1'b1;
            dec.unit      = U_ADD;
            dec.upd_arith = 1'b1;
         end
         OP_NOT, OP_XOR, OP_AND, OP_OR: begin
            dec.legal = 1'b1;
            dec.unit  = U_LOGIC;
            dec.upd_z = 1'b1;
         end
         OP_SHL, OP_SHR: begin
            dec.legal  = 1'b1;
            dec.unit   = U_SHIFT;
            dec.upd_cz = 1'b1;
         end
         OP_ROL, OP_ROR: begin
            dec.legal = 1'b1;
            dec.unit  = U_SHIFT;
         end
         OP_SWP: begin
            dec.legal = 1'b1;
            dec.unit  = U_SWAP;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/opalu_adder.sv
module opalu_adder #(
   parameter int WIDTH = 16,
   parameter int SEGS  = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   input  logic             use_one,
   output logic [WIDTH-1:0] sum,
   output logic [SEGS:0]    seg_carry,
   output logic             ovf
);

   localparam int SEG_W = WIDTH / SEGS;

   if (WIDTH % SEGS != 0) begin : g_bad_seg
      $error("opalu_adder: WIDTH must split evenly into SEGS segments");
   end

   logic [WIDTH-1:0] b_sel;
   logic [WIDTH-1:0] b_eff;

   assign b_sel        = use_one ? WIDTH'(1) : b;
   assign b_eff        = sub ? ~b_sel : b_sel;
   assign seg_carry[0] = sub;

   for (genvar g = 0; g < SEGS; g++) begin : g_seg
      assign {seg_carry[g+1], sum[g*SEG_W +: SEG_W]} =
         {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, b_eff[g*SEG_W +: SEG_W]}
         + {{SEG_W{1'b0}}, seg_carry[g]};
   end

   assign ovf = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);

endmodule

// File: rtl/opalu_logic.sv
module opalu_logic #(
   parameter int WIDTH = 16
) (
   input  logic [1:0]       sel,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      unique case (sel)
         2'b00: y = ~a;
         2'b01: y = a ^ b;
         2'b10: y = a & b;
         2'b11: y = a | b;
      endcase
   end

endmodule

// File: rtl/opalu_shift.sv
module opalu_shift #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic             right,
   input  logic             rotate,
   input  logic             cin,
   output logic [WIDTH-1:0] y,
   output logic             cout
);

   logic fill;

   always_comb begin
      if (right) begin
         fill = rotate ? a[0] : cin;
         y    = {fill, a[WIDTH-1:1]};
         cout = a[0];
      end else begin
         fill = rotate ? a[WIDTH-1] : cin;
         y    = {a[WIDTH-2:0], fill};
         cout = a[WIDTH-1];
      end
   end

endmodule

// File: rtl/opalu.sv
module opalu
   import opalu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [7:0]        opcode,
   input  logic [WIDTH-1:0]  dst_i,
   input  logic [WIDTH-1:0]  src_i,
   output logic [WIDTH-1:0]  result_o,
   output logic              illegal_o,
   output logic [FLAG_W-1:0] flags_o
);

   localparam int SEGS   = 4;
   localparam int HALF_W = WIDTH / 2;

   if (WIDTH % 8 != 0 || WIDTH < 8) begin : g_bad_width
      $error("opalu: WIDTH must be a multiple of 8 and at least 8");
   end

   dec_t              dec;
   logic [WIDTH-1:0]  add_y, log_y, sh_y, swp_y;
   logic [SEGS:0]     seg_c;
   logic              add_v, sh_c;
   logic              res_zero;
   logic [FLAG_W-1:0] flags_q, flags_d;

   opalu_decode u_dec (
      .opcode (opcode),
      .dec    (dec)
   );

   opalu_adder #(.WIDTH(WIDTH), .SEGS(SEGS)) u_add (
      .a         (dst_i),
      .b         (src_i),
      .sub       (opcode[5]),
      .use_one   (opcode[4]),
      .sum       (add_y),
      .seg_carry (seg_c),
      .ovf       (add_v)
   );

   opalu_logic #(.WIDTH(WIDTH)) u_log (
      .sel (opcode[1:0]),
      .a   (dst_i),
      .b   (src_i),
      .y   (log_y)
   );

   opalu_shift #(.WIDTH(WIDTH)) u_sh (
      .a      (dst_i),
      .right  (opcode[0]),
      .rotate (opcode[4]),
      .cin    (flags_q[F_C]),
      .y      (sh_y),
      .cout   (sh_c)
   );

   assign swp_y = {dst_i[HALF_W-1:0], dst_i[WIDTH-1:HALF_W]};

   always_comb begin
      unique case (dec.unit)
         U_ADD:   result_o = add_y;
         U_LOGIC: result_o = log_y;
         U_SHIFT: result_o = sh_y;
         U_SWAP:  result_o = swp_y;
         default: result_o = '0;
      endcase
   end

   assign illegal_o = ~dec.legal;
   assign res_zero  = (result_o == '0);

   always_comb begin
      flags_d = flags_q;
      if (dec.upd_arith) begin
         flags_d[F_C]  = seg_c[4];
         flags_d[F_QC] = seg_c[1];
         flags_d[F_HC] = seg_c[2];
         flags_d[F_TC] = seg_c[3];
         flags_d[F_Z]  = res_zero;
         flags_d[F_N]  = result_o[WIDTH-1];
         flags_d[F_V]  = add_v;
      end
      if (dec.upd_cz) begin
         flags_d[F_C] = sh_c;
         flags_d[F_Z] = res_zero;
      end
      if (dec.upd_z) begin
         flags_d[F_Z] = res_zero;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_q <= '0;
      else if (en && dec.legal)
         flags_q <= flags_d;
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/opalu_chk.sv
module opalu_chk
   import opalu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [7:0]        opcode,
   input logic [WIDTH-1:0]  dst_i,
   input logic [WIDTH-1:0]  src_i,
   input logic [WIDTH-1:0]  result_o,
   input logic              illegal_o,
   input logic [FLAG_W-1:0] flags_o
);

   logic is_arith, is_logic, is_quiet;
   assign is_arith = (opcode == OP_ADD) || (opcode == OP_INC) ||
                     (opcode == OP_SUB) || (opcode == OP_DEC);
   assign is_logic = (opcode[7:2] == 6'b010000);
   assign is_quiet = (opcode == OP_ROL) || (opcode == OP_ROR) || (opcode == OP_SWP);

   // R1
   illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (result_o == '0));

   // R2
   add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_ADD) |-> (result_o == WIDTH'(dst_i + src_i)));

   // R5
   arith_zn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && is_arith) |=> (flags_o[F_Z] == ($past(result_o) == '0)) &&
                           (flags_o[F_N] == $past(result_o[WIDTH-1])));

   // R6
   logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && is_logic) |=> (flags_o[3:0] == $past(flags_o[3:0])) &&
                           (flags_o[6:5] == $past(flags_o[6:5])));

   // R8
   quiet_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && is_quiet) |=> $stable(flags_o));

   // R10
   hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || illegal_o) |=> $stable(flags_o));

endmodule

bind opalu opalu_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .opcode    (opcode),
   .dst_i     (dst_i),
   .src_i     (src_i),
   .result_o  (result_o),
   .illegal_o (illegal_o),
   .flags_o   (flags_o)
);

// File: tb/opalu_tb.sv
module opalu_tb;

   localparam int CLK_P = 10;

   typedef struct {
      logic [15:0] res;
      logic        ill;
      logic [6:0]  flg;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [15:0] dst_i = '0;
   logic [15:0] src_i = '0;
   logic [15:0] result_o;
   logic        illegal_o;
   logic [6:0]  flags_o;

   item_t       sb[$];
   logic [6:0]  mdl_f = '0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;

   always #(CLK_P/2) clk = ~clk;

   opalu u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .opcode    (opcode),
      .dst_i     (dst_i),
      .src_i     (src_i),
      .result_o  (result_o),
      .illegal_o (illegal_o),
      .flags_o   (flags_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference model written from the requirements.
   task automatic model(input logic [7:0] op, input logic [15:0] d, input logic [15:0] s,
                        input logic [6:0] fi, output logic [15:0] r, output logic ill,
                        output logic [6:0] fo);
      logic [15:0] b;
      int          ci, tot;
      fo = fi; ill = 1'b0; r = '0;
      case (op)
         8'h45, 8'h55, 8'h65, 8'h75: begin
            b  = op[4] ? 16'd1 : s;
            if (op[5]) b = ~b;
            ci = op[5] ? 1 : 0;
            tot = int'(d) + int'(b) + ci;
            r = tot[15:0];
            fo[0] = tot[16];
            fo[1] = ((int'(d[3:0]) + int'(b[3:0]) + ci) >= 16);
            fo[2] = ((int'(d[7:0]) + int'(b[7:0]) + ci) >= 256);
            fo[3] = ((int'(d[11:0]) + int'(b[11:0]) + ci) >= 4096);
            fo[4] = (r == 0);
            fo[5] = r[15];
            fo[6] = (d[15] == b[15]) && (r[15] != d[15]);
         end
         8'h40: begin r = ~d;    fo[4] = (r == 0); end
         8'h41: begin r = d ^ s; fo[4] = (r == 0); end
         8'h42: begin r = d & s; fo[4] = (r == 0); end
         8'h43: begin r = d | s; fo[4] = (r == 0); end
         8'h46: begin r = {d[14:0], fi[0]}; fo[0] = d[15]; fo[4] = (r == 0); end
         8'h47: begin r = {fi[0], d[15:1]}; fo[0] = d[0];  fo[4] = (r == 0); end
         8'h56: r = {d[14:0], d[15]};
         8'h57: r = {d[0], d[15:1]};
         8'h48: r = {d[7:0], d[15:8]};
         default: ill = 1'b1;
      endcase
   endtask

   task automatic drive(input logic [7:0] op, input logic [15:0] d, input logic [15:0] s,
                        input logic e, input string tag);
      item_t       it;
      logic [15:0] r;
      logic        ill;
      logic [6:0]  fo;
      @(negedge clk);
      opcode = op; dst_i = d; src_i = s; en = e;
      model(op, d, s, mdl_f, r, ill, fo);
      if (e && !ill) mdl_f = fo;
      it.res = r; it.ill = ill; it.flg = mdl_f; it.tag = tag;
      sb.push_back(it);
   endtask

   // Monitor: result mid-cycle, flags just after the edge.
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            check({it.tag, " result"}, 32'(result_o), 32'(it.res));
            check({it.tag, " illegal"}, 32'(illegal_o), 32'(it.ill));
            @(posedge clk);
            #2;
            check({it.tag, " flags"}, 32'(flags_o), 32'(it.flg));
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   localparam logic [7:0] LEGAL [13] = '{8'h40, 8'h41, 8'h42, 8'h43, 8'h45, 8'h46, 8'h47,
                                         8'h48, 8'h55, 8'h56, 8'h57, 8'h65, 8'h75};

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R11 flags in reset", 32'(flags_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R11 flags after reset", 32'(flags_o), 32'h0);

      drive(8'h45, 16'h1234, 16'h0101, 1, "R2 add plain");
      drive(8'h45, 16'hFFFF, 16'h0001, 1, "R4 add all carries zero");
      drive(8'h45, 16'h0F0F, 16'h0001, 1, "R4 add quarter carry");
      drive(8'h45, 16'h7FFF, 16'h0001, 1, "R5 add overflow");
      drive(8'h55, 16'h00FF, 16'h9999, 1, "R2 inc ignores src");
      drive(8'h65, 16'h5555, 16'h5555, 1, "R3 sub equal");
      drive(8'h65, 16'h0003, 16'h0005, 1, "R3 sub borrow");
      drive(8'h75, 16'h0000, 16'h0000, 1, "R3 dec zero");
      drive(8'h75, 16'h8000, 16'h0000, 1, "R5 dec overflow");
      drive(8'h45, 16'hFFFF, 16'hFFFF, 1, "R4 add set flags");
      drive(8'h42, 16'hF0F0, 16'h0F0F, 1, "R6 and zero");
      drive(8'h43, 16'hF000, 16'h000F, 1, "R6 or");
      drive(8'h41, 16'hAAAA, 16'hAAAA, 1, "R6 xor zero");
      drive(8'h40, 16'h00FF, 16'h0000, 1, "R6 not");
      drive(8'h45, 16'h8000, 16'h8000, 1, "R4 add set carry");
      drive(8'h46, 16'h4001, 16'h0000, 1, "R7 shl carry in 1");
      drive(8'h46, 16'h8000, 16'h0000, 1, "R7 shl to zero");
      drive(8'h47, 16'h0001, 16'h0000, 1, "R7 shr carry out");
      drive(8'h47, 16'h0002, 16'h0000, 1, "R7 shr carry in");
      drive(8'h56, 16'h8001, 16'h0000, 1, "R8 rol");
      drive(8'h57, 16'h8001, 16'h0000, 1, "R8 ror");
      drive(8'h48, 16'h12AB, 16'h0000, 1, "R9 swap");
      drive(8'h44, 16'h1234, 16'h1111, 1, "R1 illegal in class");
      drive(8'h49, 16'hFFFF, 16'h0001, 1, "R1 illegal 0x49");
      drive(8'hC0, 16'hFFFF, 16'h0001, 1, "R1 illegal other class");
      drive(8'h00, 16'h0000, 16'h0000, 1, "R1 illegal zero code");
      drive(8'h45, 16'hFFFF, 16'h0001, 0, "R10 add disabled");
      drive(8'h46, 16'h8000, 16'h0000, 0, "R10 shift disabled");

      for (int i = 0; i < 400; i++) begin
         logic [7:0] op;
         if ($urandom_range(0, 9) == 0) op = 8'($urandom);
         else op = LEGAL[$urandom_range(0, 12)];
         drive(op, 16'($urandom), 16'($urandom), ($urandom_range(0, 7) != 0), "R10 random");
      end

      @(negedge clk);
      en = 1'b0;
      while (sb.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule